// File: doc/BRIEF.md
# Microprogram Sequencer with Branch Control

This block steps a microcoded control unit through its microprogram. A micro-address register points into a small read-only control store. A micro-instruction register holds the control word that is currently executing. On every clock the sequencer picks the next micro-address from one of four sources: the current address plus one, a start address looked up from the machine opcode, an externally supplied address, or the branch target carried in the current word. The branch-control field of the current word picks the source, together with the sign, zero, condition and count-status flags.

The control field of the micro-instruction register is the block's main output. It goes to a datapath that is not part of this block, and it comes straight from a register. The current micro-address is also brought out. The store holds a fixed test microprogram that places every branch-control code at a known address, so each sequencing rule can be reached from outside.

Top module: `useq_top`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the micro-address to RESET_ADDR (default 8) and clears the control output to zero. On the first edge after release, the micro-instruction register loads the word at that address while the micro-address holds.
- R2: A micro-instruction is packed as {control field CW bits, branch target AW bits, branch code 4 bits}, most significant first. After priming, `ctrl` always equals the control field of the word at `upc`, one register after the word's address was chosen.
- R3: Branch code 0 advances to the current micro-address plus one, wrapping modulo 2^AW. Branch code 1 jumps to the branch target unconditionally.
- R4: Code 2 branches to the target when `flag_z` is 1. Code 3 branches when `flag_z` is 0.
- R5: Code 4 (positive) branches when both `flag_n` and `flag_z` are 0. Code 5 (negative) branches when `flag_n` is 1.
- R6: Code 8 branches when `flag_con` is 0. Code 9 branches when `cnt_one` is 1. Code 10 branches when `cnt_zero` is 1.
- R7: Whenever the test of a conditional code (2, 3, 4, 5, 8, 9, 10) fails, the next micro-address is the current one plus one.
- R8: Code 6 dispatches to the opcode start address, which is OPC_BASE + `opcode` (default base 4).
- R9: Code 7 loads `ext_addr`. Code 11 (end of routine) returns to FETCH_ADDR (default 0).
- R10: The unassigned codes 12 to 15 behave like code 0.
- R11: In the test microprogram, the word at address a has control field (37·a + 11) mod 256. For a in 4..15 its branch code is a−2 and its target is 20. Address 1 holds code 1 with target 30. Every other word holds code 0 with target 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | OPW | Machine opcode used by the dispatch code |
| ext_addr | input | AW | External micro-address (reset or exception entry) |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_con | input | 1 | Condition flag for the count-driven variant |
| cnt_one | input | 1 | Shift count equals one |
| cnt_zero | input | 1 | Shift count equals zero |
| ctrl | output | CW | Registered control-signal field |
| upc | output | AW | Current micro-address |

## Verification
A wrong next-address choice shows at `upc` on the very next rising edge. Because the register is loaded from the store at the chosen address in the same edge, `ctrl` is wrong in that same cycle too. A flag test that is inverted or swapped sends the address to the target instead of address+1 (or the reverse), and the divergence is visible one cycle after the word is entered. The sweep enters every store address under every flag combination and follows two further steps, so a fault also shows up as a wrong follow-on path.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;

    localparam int UBW = 4;

    typedef enum logic [1:0] {
        SEL_INC = 2'b00,
        SEL_OPC = 2'b01,
        SEL_EXT = 2'b10,
        SEL_BR  = 2'b11
    } nsel_e;

    typedef enum logic [UBW-1:0] {
        BC_SEQ   = 4'd0,
        BC_JMP   = 4'd1,
        BC_Z     = 4'd2,
        BC_NZ    = 4'd3,
        BC_POS   = 4'd4,
        BC_NEG   = 4'd5,
        BC_DISP  = 4'd6,
        BC_EXT   = 4'd7,
        BC_CON0  = 4'd8,
        BC_CNT1  = 4'd9,
        BC_CNT0  = 4'd10,
        BC_END   = 4'd11
    } bcode_e;

endpackage

// File: rtl/useq_rom.sv
`timescale 1ns/1ps
module useq_rom
    import useq_pkg::*;
#(
    parameter int CW = 8,
    parameter int AW = 5
) (
    input  logic [AW-1:0]        rd_addr,
    output logic [CW+AW+UBW-1:0] rd_word
);
    localparam int DEPTH = 1 << AW;
    localparam int IW    = CW + AW + UBW;

    logic [IW-1:0] mem [DEPTH];

    // Fixed test microprogram: codes 2..13 at addresses 4..15, a jump at 1.
    for (genvar a = 0; a < DEPTH; a++) begin : g_word
        localparam int CODE = (a >= 4 && a <= 15) ? a - 2 : ((a == 1) ? 1 : 0);
        localparam int TGT  = (a >= 4 && a <= 15) ? 20 : ((a == 1) ? 30 : 0);
        localparam int CVAL = (a * 37 + 11) % 256;
        assign mem[a] = {CW'(CVAL), AW'(TGT), UBW'(CODE)};
    end

    assign rd_word = mem[rd_addr];

endmodule

// File: rtl/useq_opmap.sv
`timescale 1ns/1ps
module useq_opmap #(
    parameter int AW       = 5,
    parameter int OPW      = 3,
    parameter int OPC_BASE = 4
) (
    input  logic [OPW-1:0] opcode,
    output logic [AW-1:0]  start_addr
);
    localparam int NOP = 1 << OPW;

    logic [AW-1:0] table_q [NOP];

    for (genvar k = 0; k < NOP; k++) begin : g_ent
        assign table_q[k] = AW'(OPC_BASE + k);
    end

    assign start_addr = table_q[opcode];

endmodule

// File: rtl/useq_brsel.sv
`timescale 1ns/1ps
module useq_brsel
    import useq_pkg::*;
(
    input  logic [UBW-1:0] bctl,
    input  logic           flag_n,
    input  logic           flag_z,
    input  logic           flag_con,
    input  logic           cnt_one,
    input  logic           cnt_zero,
    output nsel_e          sel,
    output logic           end_hit
);
    always_comb begin
        sel     = SEL_INC;
        end_hit = 1'b0;
        case (bctl)
            BC_JMP:  sel = SEL_BR;
            BC_Z:    sel = flag_z   ? SEL_BR : SEL_INC;
            BC_NZ:   sel = !flag_z  ? SEL_BR : SEL_INC;
            BC_POS:  sel = (!flag_n && !flag_z) ? SEL_BR : SEL_INC;
            BC_NEG:  sel = flag_n   ? SEL_BR : SEL_INC;
            BC_DISP: sel = SEL_OPC;
            BC_EXT:  sel = SEL_EXT;
            BC_CON0: sel = !flag_con ? SEL_BR : SEL_INC;
            BC_CNT1: sel = cnt_one  ? SEL_BR : SEL_INC;
            BC_CNT0: sel = cnt_zero ? SEL_BR : SEL_INC;
            BC_END: begin
                sel     = SEL_BR;
                end_hit = 1'b1;
            end
            default: sel = SEL_INC;
        endcase
    end

endmodule

// File: rtl/useq_nextmux.sv
`timescale 1ns/1ps
module useq_nextmux
    import useq_pkg::*;
#(
    parameter int AW = 5
) (
    input  nsel_e         sel,
    input  logic [AW-1:0] inc_addr,
    input  logic [AW-1:0] opc_addr,
    input  logic [AW-1:0] ext_addr,
    input  logic [AW-1:0] br_addr,
    output logic [AW-1:0] next_addr
);
    always_comb begin
        case (sel)
            SEL_INC: next_addr = inc_addr;
            SEL_OPC: next_addr = opc_addr;
            SEL_EXT: next_addr = ext_addr;
            default: next_addr = br_addr;
        endcase
    end

endmodule

// File: rtl/useq_top.sv
`timescale 1ns/1ps
module useq_top
    import useq_pkg::*;
#(
    parameter int CW         = 8,
    parameter int AW         = 5,
    parameter int OPW        = 3,
    parameter int RESET_ADDR = 8,
    parameter int FETCH_ADDR = 0,
    parameter int OPC_BASE   = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] opcode,
    input  logic [AW-1:0]  ext_addr,
    input  logic           flag_n,
    input  logic           flag_z,
    input  logic           flag_con,
    input  logic           cnt_one,
    input  logic           cnt_zero,
    output logic [CW-1:0]  ctrl,
    output logic [AW-1:0]  upc
);
    localparam int IW = CW + AW + UBW;

    typedef struct packed {
        logic [CW-1:0]  ctrl;
        logic [AW-1:0]  baddr;
        logic [UBW-1:0] bctl;
    } uword_t;

    typedef struct packed {
        logic [AW-1:0] upc;
        uword_t        uir;
        logic          primed;
    } state_t;

    state_t        st_q, st_d;
    logic [IW-1:0] rom_word;
    logic [AW-1:0] inc_addr, opc_addr, br_target, mux_out, rd_addr;
    nsel_e         sel;
    logic          end_hit;

    assign inc_addr = st_q.upc + AW'(1);

    useq_brsel u_brsel (
        .bctl     (st_q.uir.bctl),
        .flag_n   (flag_n),
        .flag_z   (flag_z),
        .flag_con (flag_con),
        .cnt_one  (cnt_one),
        .cnt_zero (cnt_zero),
        .sel      (sel),
        .end_hit  (end_hit)
    );

    assign br_target = end_hit ? AW'(FETCH_ADDR) : st_q.uir.baddr;

    useq_opmap #(.AW(AW), .OPW(OPW), .OPC_BASE(OPC_BASE)) u_opmap (
        .opcode     (opcode),
        .start_addr (opc_addr)
    );

    useq_nextmux #(.AW(AW)) u_mux (
        .sel       (sel),
        .inc_addr  (inc_addr),
        .opc_addr  (opc_addr),
        .ext_addr  (ext_addr),
        .br_addr   (br_target),
        .next_addr (mux_out)
    );

    // Before priming the store is read at the held reset address.
    assign rd_addr = st_q.primed ? mux_out : st_q.upc;

    useq_rom #(.CW(CW), .AW(AW)) u_rom (
        .rd_addr (rd_addr),
        .rd_word (rom_word)
    );

    always_comb begin
        st_d        = st_q;
        st_d.upc    = rd_addr;
        st_d.uir    = uword_t'(rom_word);
        st_d.primed = 1'b1;
        if (rst) begin
            st_d.upc    = AW'(RESET_ADDR);
            st_d.uir    = '0;
            st_d.primed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ctrl = st_q.uir.ctrl;
    assign upc  = st_q.upc;

    // R1: the address holds during the priming cycle
    assert_prime_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !st_q.primed |=> upc == $past(upc));
    // R1: control output is zero until primed
    assert_ctrl_clear_R1: assert property (@(posedge clk) disable iff (rst)
        !st_q.primed |-> ctrl == '0);
    // R3: sequential step
    assert_seq_step_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q.primed && st_q.uir.bctl == BC_SEQ) |=> upc == $past(upc) + AW'(1));
    // R3: unconditional jump
    assert_jump_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q.primed && st_q.uir.bctl == BC_JMP) |=> upc == $past(st_q.uir.baddr));
    // R4: zero test taken
    assert_z_taken_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q.primed && st_q.uir.bctl == BC_Z && flag_z) |=> upc == $past(st_q.uir.baddr));
    // R7: failed zero test falls through
    assert_z_fall_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q.primed && st_q.uir.bctl == BC_Z && !flag_z) |=> upc == $past(upc) + AW'(1));
    // R9: end of routine returns to fetch
    assert_end_fetch_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q.primed && st_q.uir.bctl == BC_END) |=> upc == AW'(FETCH_ADDR));
    // R9: external entry
    assert_ext_entry_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q.primed && st_q.uir.bctl == BC_EXT) |=> upc == $past(ext_addr));

endmodule

// File: tb/useq_top_tb.sv
`timescale 1ns/1ps
module useq_top_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] opcode = '0;
    logic [4:0] ext_addr = '0;
    logic       flag_n = 1'b0, flag_z = 1'b0, flag_con = 1'b0;
    logic       cnt_one = 1'b0, cnt_zero = 1'b0;
    logic [7:0] ctrl;
    logic [4:0] upc;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    useq_top u_dut (
        .clk(clk), .rst(rst), .opcode(opcode), .ext_addr(ext_addr),
        .flag_n(flag_n), .flag_z(flag_z), .flag_con(flag_con),
        .cnt_one(cnt_one), .cnt_zero(cnt_zero), .ctrl(ctrl), .upc(upc)
    );

    function automatic int ctrl_of(int a);
        return (a * 37 + 11) % 256;
    endfunction

    function automatic int code_of(int a);
        if (a >= 4 && a <= 15) return a - 2;
        if (a == 1) return 1;
        return 0;
    endfunction

    function automatic int tgt_of(int a);
        if (a >= 4 && a <= 15) return 20;
        if (a == 1) return 30;
        return 0;
    endfunction

    function automatic int next_of(int a, int op, int ext, bit n, bit z, bit con, bit c1, bit c0);
        int t   = tgt_of(a);
        int inc = (a + 1) % 32;
        case (code_of(a))
            1:  return t;
            2:  return z ? t : inc;
            3:  return !z ? t : inc;
            4:  return (!n && !z) ? t : inc;
            5:  return n ? t : inc;
            6:  return 4 + op;
            7:  return ext;
            8:  return !con ? t : inc;
            9:  return c1 ? t : inc;
            10: return c0 ? t : inc;
            11: return 0;
            default: return inc;
        endcase
    endfunction

    function automatic string req_of(int a);
        case (code_of(a))
            0, 12, 13: return "R10/R3";
            1:         return "R3";
            2, 3:      return "R4/R7";
            4, 5:      return "R5/R7";
            6:         return "R8";
            7, 11:     return "R9";
            8, 9, 10:  return "R6/R7";
            default:   return "R3";
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R8: opcode dispatch sweep from the reset word (code 6 at address 8)
        for (int op = 0; op < 8; op++) begin
            opcode = 3'(op);
            rst = 1'b1;
            tick();
            chk("R1 reset upc", int'(upc), 8);
            chk("R1 reset ctrl", int'(ctrl), 0);
            rst = 1'b0;
            tick();
            chk("R1 prime upc", int'(upc), 8);
            chk("R2 prime ctrl", int'(ctrl), ctrl_of(8));
            tick();
            chk("R8 dispatch", int'(upc), 4 + op);
            chk("R11 dispatch ctrl", int'(ctrl), ctrl_of(4 + op));
        end

        // Sweep every address under every flag combination, via external entry.
        for (int a = 0; a < 32; a++) begin
            for (int f = 0; f < 32; f++) begin
                int n1, n2;
                opcode   = 3'd5;
                ext_addr = 5'(a);
                flag_n   = f[0];
                flag_z   = f[1];
                flag_con = f[2];
                cnt_one  = f[3];
                cnt_zero = f[4];
                rst = 1'b1;
                tick();
                chk("R1 reset upc", int'(upc), 8);
                rst = 1'b0;
                tick();
                tick();
                chk("R8 dispatch op5", int'(upc), 9);
                tick();
                chk("R9 external entry", int'(upc), a);
                chk("R2 ctrl at entry", int'(ctrl), ctrl_of(a));
                n1 = next_of(a, 5, a, f[0], f[1], f[2], f[3], f[4]);
                tick();
                chk(req_of(a), int'(upc), n1);
                chk("R11 ctrl step1", int'(ctrl), ctrl_of(n1));
                n2 = next_of(n1, 5, a, f[0], f[1], f[2], f[3], f[4]);
                tick();
                chk(req_of(n1), int'(upc), n2);
                chk("R2 ctrl step2", int'(ctrl), ctrl_of(n2));
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule